// File: doc/BRIEF.md
# Way-Linked Instruction Cache

This block is a small set-associative instruction cache that saves lookup energy by remembering, for every resident line, which way holds the line directly above it in the address space and which way holds the line directly below it. Instruction fetch mostly walks forward through memory or makes short jumps into the next or previous line. For those moves the cache already knows the destination way. It reads one data way and enables no tag way.

With no usable link, the fetch falls back to a parallel lookup of every tag way and every data way. When that lookup hits a neighbour of the previous fetch, the cache records the way it found, in both directions. A miss fetches a whole line from a simple memory port and places it in the way chosen by a global round-robin counter. The refill also links the new line to the previous line when the two are neighbours.

When a line is evicted, the cache clears only the links held by the two neighbouring sets that name the victim way. A stale way is therefore never trusted. For every lookup the block reports which tag ways and which data ways it powered, as masks and as counts.

Top module: `linkway_icache`

## Requirements
- R1: After reset, rsp_valid, tag_en, data_en and mem_req are 0 and fetch_ready is 1.
- R2: A miss drives tag_en and data_en to all ones in the cycle after the fetch is accepted. It raises mem_req for exactly one cycle, with mem_addr set to the line-aligned byte address, and it holds fetch_ready low until the refill ends. After the last of the LINE_WORDS beats, the cache returns rsp_valid with rsp_hit=0 and the requested word.
- R3: A fetch in the same line as the previous fetch hits with tag_en=0 and with data_en one-hot at the way holding the line.
- R4: A fetch into the next line (line address +1), whether sequential or branch, uses a valid forward link. It enables exactly one data way and no tag way, and it returns the correct word.
- R5: A fetch into the previous line (line address -1) uses the backward link only when fetch_br=1. With fetch_br=0 it does a full lookup (tag_en and data_en all ones).
- R6: A full-lookup hit on a neighbour of the previous fetch creates links in both directions, so the same move made later is linked.
- R7: A refill of a line that neighbours the previous fetch links the two lines in both directions.
- R8: The victim way is taken from one round-robin counter shared by all sets. It starts at 0 and advances by one per refill. The way holding a line is seen as the set bit of data_en on a linked hit (bit i = way i).
- R9: Evicting a line clears every link that names it. A later fetch that would have followed such a link does a full lookup and returns the correct data.
- R10: A hit returns rsp_valid with rsp_hit=1 in the cycle after acceptance, and back-to-back hits complete one per cycle.
- R11: tag_cnt and data_cnt equal the number of bits set in tag_en and data_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request strobe |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_br | input | 1 | 1 = branch target, 0 = sequential fetch |
| fetch_ready | output | 1 | Cache can accept a fetch (no refill in progress) |
| rsp_valid | output | 1 | Instruction word returned this cycle |
| rsp_hit | output | 1 | The returned word came from a hit |
| rsp_data | output | DATA_W | Instruction word |
| tag_en | output | WAYS | Tag ways enabled by the lookup of the previous cycle |
| data_en | output | WAYS | Data ways enabled by the lookup of the previous cycle |
| tag_cnt | output | clog2(WAYS+1) | Number of tag ways enabled |
| data_cnt | output | clog2(WAYS+1) | Number of data ways enabled |
| mem_req | output | 1 | One-cycle line refill request |
| mem_addr | output | ADDR_W | Line-aligned refill address |
| mem_rvalid | input | 1 | Refill beat strobe |
| mem_rdata | input | DATA_W | Refill beat data, words in ascending order |

## Verification
The assertions check every cycle that any link the cache follows names a way that is valid and holds the requested tag. They also check that a linked fetch yields a hit with one data way and no tag way, that every hit reports either that shape or a full lookup, and that the refill request is a single pulse raised only after a full lookup, with the cache busy. Whether the correct way was chosen, whether links are created in both directions, and whether eviction really forces a fresh lookup can only be shown by the bench scenarios. Those scenarios walk lines forward and backward, rotate the victim counter through all ways of one set, and revisit neighbours of an evicted line.

// File: rtl/linkway_icache.sv
module linkway_icache #(
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_valid,
  input  logic [ADDR_W-1:0]          fetch_addr,
  input  logic                       fetch_br,
  output logic                       fetch_ready,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [DATA_W-1:0]          rsp_data,
  output logic [WAYS-1:0]            tag_en,
  output logic [WAYS-1:0]            data_en,
  output logic [$clog2(WAYS+1)-1:0]  tag_cnt,
  output logic [$clog2(WAYS+1)-1:0]  data_cnt,
  output logic                       mem_req,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic                       mem_rvalid,
  input  logic [DATA_W-1:0]          mem_rdata
);
  localparam int WB_W  = $clog2(DATA_W / 8);
  localparam int WD_W  = $clog2(LINE_WORDS);
  localparam int OFF_W = WB_W + WD_W;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LA_W - SET_W;
  localparam int CNT_W = $clog2(WAYS + 1);

  logic [WAYS-1:0]   vld [SETS];
  logic [TAG_W-1:0]  tag_mem [SETS][WAYS];
  logic [DATA_W-1:0] data_mem [SETS][WAYS][LINE_WORDS];
  logic [WAYS-1:0]   nlv [SETS];
  logic [WAYS-1:0]   plv [SETS];
  logic [WAY_W-1:0]  nlw [SETS][WAYS];
  logic [WAY_W-1:0]  plw [SETS][WAYS];

  logic              busy;
  logic [WAY_W-1:0]  rr;
  logic              cur_valid;
  logic [LA_W-1:0]   cur_line;
  logic [WAY_W-1:0]  cur_way;
  logic [SET_W-1:0]  fill_set;
  logic [TAG_W-1:0]  fill_tag;
  logic [WD_W-1:0]   fill_word;
  logic [WAY_W-1:0]  fill_way;
  logic              fill_nx, fill_pv;
  logic [DATA_W-1:0] fill_data;
  logic [WD_W-1:0]   beat;

  logic [LA_W-1:0]   req_line;
  logic [SET_W-1:0]  req_set, cur_set, up_set, dn_set;
  logic [TAG_W-1:0]  req_tag;
  logic [WD_W-1:0]   req_word;
  logic              is_same, is_next, is_prev, lnk_use, hit, look, last_beat;
  logic [WAY_W-1:0]  lnk_way, hit_way, way_sel;
  logic [WAYS-1:0]   match;
  logic [DATA_W-1:0] rd_word;
  logic              lnk_line_ok;
  logic              unused_lsb;

  assign req_line   = fetch_addr[ADDR_W-1:OFF_W];
  assign req_set    = req_line[SET_W-1:0];
  assign req_tag    = req_line[LA_W-1:SET_W];
  assign req_word   = fetch_addr[OFF_W-1:WB_W];
  assign unused_lsb = ^fetch_addr[WB_W-1:0];
  assign cur_set    = cur_line[SET_W-1:0];
  assign up_set     = req_set + SET_W'(1);
  assign dn_set     = req_set - SET_W'(1);

  assign fetch_ready = !busy;
  assign look        = fetch_valid && !busy;
  assign is_same = cur_valid && (req_line == cur_line);
  assign is_next = cur_valid && (req_line == cur_line + LA_W'(1));
  assign is_prev = cur_valid && fetch_br && (req_line == cur_line - LA_W'(1));
  assign lnk_use = is_same || (is_next && nlv[cur_set][cur_way]) || (is_prev && plv[cur_set][cur_way]);
  assign lnk_way = is_same ? cur_way : (is_next ? nlw[cur_set][cur_way] : plw[cur_set][cur_way]);

  always_comb begin
    match   = '0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      match[w] = vld[req_set][w] && (tag_mem[req_set][w] == req_tag);
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WAY_W'(w);
  end

  assign hit         = lnk_use || (|match);
  assign way_sel     = lnk_use ? lnk_way : hit_way;
  assign rd_word     = data_mem[req_set][way_sel][req_word];
  assign lnk_line_ok = vld[req_set][lnk_way] && (tag_mem[req_set][lnk_way] == req_tag);
  assign last_beat   = (beat == WD_W'(LINE_WORDS - 1));
  assign tag_cnt     = CNT_W'($countones(tag_en));
  assign data_cnt    = CNT_W'($countones(data_en));

  always_ff @(posedge clk)
    if (busy && mem_rvalid) begin
      data_mem[fill_set][fill_way][beat] <= mem_rdata;
      if (last_beat) tag_mem[fill_set][fill_way] <= fill_tag;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rr <= '0;
      cur_valid <= 1'b0; cur_line <= '0; cur_way <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_data <= '0;
      tag_en <= '0; data_en <= '0; mem_req <= 1'b0; mem_addr <= '0;
      fill_set <= '0; fill_tag <= '0; fill_word <= '0; fill_way <= '0;
      fill_nx <= 1'b0; fill_pv <= 1'b0; fill_data <= '0; beat <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0; nlv[s] <= '0; plv[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          nlw[s][w] <= '0; plw[s][w] <= '0;
        end
      end
    end else begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0;
      tag_en <= '0; data_en <= '0; mem_req <= 1'b0;
      if (look) begin
        tag_en  <= lnk_use ? '0 : '1;
        data_en <= lnk_use ? (WAYS'(1) << way_sel) : '1;
        if (hit) begin
          rsp_valid <= 1'b1; rsp_hit <= 1'b1; rsp_data <= rd_word;
          cur_valid <= 1'b1; cur_line <= req_line; cur_way <= way_sel;
          if (!lnk_use && is_next) begin
            nlv[cur_set][cur_way] <= 1'b1; nlw[cur_set][cur_way] <= hit_way;
            plv[req_set][hit_way] <= 1'b1; plw[req_set][hit_way] <= cur_way;
          end
          if (!lnk_use && is_prev) begin
            plv[cur_set][cur_way] <= 1'b1; plw[cur_set][cur_way] <= hit_way;
            nlv[req_set][hit_way] <= 1'b1; nlw[req_set][hit_way] <= cur_way;
          end
        end else begin
          busy <= 1'b1; mem_req <= 1'b1;
          mem_addr <= {req_line, {OFF_W{1'b0}}};
          fill_set <= req_set; fill_tag <= req_tag; fill_word <= req_word;
          fill_way <= rr; rr <= rr + WAY_W'(1);
          fill_nx <= is_next; fill_pv <= is_prev; beat <= '0;
          vld[req_set][rr] <= 1'b0;
          nlv[req_set][rr] <= 1'b0;
          plv[req_set][rr] <= 1'b0;
          for (int w = 0; w < WAYS; w++) begin
            if (plw[up_set][w] == rr) plv[up_set][w] <= 1'b0;
            if (nlw[dn_set][w] == rr) nlv[dn_set][w] <= 1'b0;
          end
          if (cur_valid && cur_set == req_set && cur_way == rr) cur_valid <= 1'b0;
        end
      end else if (busy && mem_rvalid) begin
        beat <= beat + WD_W'(1);
        if (beat == fill_word) fill_data <= mem_rdata;
        if (last_beat) begin
          busy <= 1'b0;
          vld[fill_set][fill_way] <= 1'b1;
          rsp_valid <= 1'b1; rsp_hit <= 1'b0;
          rsp_data <= (beat == fill_word) ? mem_rdata : fill_data;
          cur_valid <= 1'b1; cur_line <= {fill_tag, fill_set}; cur_way <= fill_way;
          if (fill_nx) begin
            nlv[cur_set][cur_way] <= 1'b1; nlw[cur_set][cur_way] <= fill_way;
            plv[fill_set][fill_way] <= 1'b1; plw[fill_set][fill_way] <= cur_way;
          end
          if (fill_pv) begin
            plv[cur_set][cur_way] <= 1'b1; plw[cur_set][cur_way] <= fill_way;
            nlv[fill_set][fill_way] <= 1'b1; nlw[fill_set][fill_way] <= cur_way;
          end
        end
      end
    end
  end
endmodule

// File: rtl/linkway_icache_chk.sv
module linkway_icache_chk #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic            fetch_ready,
  input logic            lnk_use,
  input logic            lnk_line_ok,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [WAYS-1:0] tag_en,
  input logic [WAYS-1:0] data_en,
  input logic            mem_req
);
  AST_LINK_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && lnk_use) |-> lnk_line_ok); // R9
  AST_LINK_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && lnk_use) |=> (rsp_valid && rsp_hit && tag_en == '0 && $countones(data_en) == 1)); // R4
  AST_HIT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> ((tag_en == '0 && $countones(data_en) == 1) || (tag_en == '1 && data_en == '1))); // R3
  AST_MISS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (tag_en == '1 && data_en == '1)); // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R2
  AST_BUSY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !fetch_ready); // R2
endmodule

bind linkway_icache linkway_icache_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .lnk_use(lnk_use), .lnk_line_ok(lnk_line_ok), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .tag_en(tag_en), .data_en(data_en), .mem_req(mem_req)
);

// File: tb/linkway_icache_bench.sv
module linkway_icache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_br = 1'b0;
  logic        fetch_ready, rsp_valid, rsp_hit, mem_req;
  logic [31:0] rsp_data, mem_addr;
  logic [3:0]  tag_en, data_en;
  logic [2:0]  tag_cnt, data_cnt;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int nchk = 0, nfail = 0;
  logic [32:0] sb [$];

  linkway_icache u_linkway_icache (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_br(fetch_br), .fetch_ready(fetch_ready), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data), .tag_en(tag_en), .data_en(data_en),
    .tag_cnt(tag_cnt), .data_cnt(data_cnt), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] wd(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input bit br, input bit hit,
                       input logic [3:0] te, input logic [3:0] de, input string req);
    logic [13:0] exp;
    while (!fetch_ready) @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; fetch_br = br;
    sb.push_back({hit, wd(a)});
    @(negedge clk);
    exp = {te, de, 3'($countones(te)), 3'($countones(de))};
    chk({tag_en, data_en, tag_cnt, data_cnt} == exp, {req, " R11 enables"},
        64'({tag_en, data_en, tag_cnt, data_cnt}), 64'(exp));
    fetch_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) chk(1'b0, "R10 unexpected response", 64'(rsp_data), 64'd0);
      else begin
        logic [32:0] e;
        e = sb.pop_front();
        chk({rsp_hit, rsp_data} == e, "R10 response", 64'({rsp_hit, rsp_data}), 64'(e));
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        logic [31:0] base;
        base = mem_addr;
        chk(base[3:0] == 4'd0, "R2 line aligned", 64'(base), 64'(base & ~32'hF));
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          mem_rvalid = 1'b1; mem_rdata = wd(base + 32'(4 * k));
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rsp_valid, tag_en, data_en, mem_req, fetch_ready} == 11'b1, "R1 reset state",
        64'({rsp_valid, tag_en, data_en, mem_req, fetch_ready}), 64'd1);
    fetch(32'h100, 0, 0, 4'hF, 4'hF, "R2 cold miss way0");
    fetch(32'h104, 0, 1, 4'h0, 4'b0001, "R3 same line");
    fetch(32'h108, 0, 1, 4'h0, 4'b0001, "R10 back-to-back");
    fetch(32'h10C, 0, 1, 4'h0, 4'b0001, "R10 back-to-back");
    fetch(32'h110, 0, 0, 4'hF, 4'hF, "R7 refill next line way1");
    fetch(32'h114, 0, 1, 4'h0, 4'b0010, "R3 same line way1");
    fetch(32'h100, 1, 1, 4'h0, 4'b0001, "R5 R7 backward link");
    fetch(32'h110, 0, 1, 4'h0, 4'b0010, "R4 R7 forward link");
    fetch(32'h104, 0, 1, 4'hF, 4'hF, "R5 backward without branch");
    fetch(32'h120, 1, 0, 4'hF, 4'hF, "R8 miss way2");
    fetch(32'h110, 1, 1, 4'hF, 4'hF, "R6 full hit creates link");
    fetch(32'h120, 0, 1, 4'h0, 4'b0100, "R6 forward link learned");
    fetch(32'h110, 1, 1, 4'h0, 4'b0010, "R6 backward link learned");
    fetch(32'h1110, 1, 0, 4'hF, 4'hF, "R8 miss way3");
    fetch(32'h1114, 0, 1, 4'h0, 4'b1000, "R8 way3");
    fetch(32'h2110, 1, 0, 4'hF, 4'hF, "R8 miss wraps to way0");
    fetch(32'h2114, 0, 1, 4'h0, 4'b0001, "R8 way0");
    fetch(32'h3110, 1, 0, 4'hF, 4'hF, "R8 miss way1 evicts");
    fetch(32'h3114, 0, 1, 4'h0, 4'b0010, "R8 way1");
    fetch(32'h120, 1, 1, 4'hF, 4'hF, "R9 reach neighbour");
    fetch(32'h110, 1, 0, 4'hF, 4'hF, "R9 backward link cleared");
    fetch(32'h120, 0, 1, 4'h0, 4'b0100, "R7 link from refill");
    fetch(32'h3110, 1, 1, 4'hF, 4'hF, "R9 detour");
    fetch(32'h100, 1, 1, 4'hF, 4'hF, "R9 reach lower neighbour");
    fetch(32'h110, 0, 1, 4'hF, 4'hF, "R9 forward link cleared");
    fetch(32'h114, 0, 1, 4'h0, 4'b0100, "R9 refilled way2");
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R10 all responses", 64'(sb.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule